// File: doc/BRIEF.md
# Memory Protection Register Bank

This block holds the per-entry registers of a hart's physical memory protection unit. Each entry has an address register and an 8-bit configuration byte. Configuration bytes are packed several to a control/status register word: four per word on a 32-bit hart and eight per word on a 64-bit hart. Software reaches every register through a single-cycle CSR port. The port has an address, a write strobe and write data, and it returns read data combinationally. The port is always ready and takes no handshake, so there is no back-pressure. A write that is filtered out is simply dropped and is not reported back.

The number of implemented entries is a parameter, `NUM_ENTRIES`. It may be anywhere from zero up to the architectural maximum `MAX_ENTRIES`. The block applies the lock rules, the legal-value rules and the hardwiring of absent entries. It drives every entry's stored configuration and address onto flat output buses for a separate match-and-permission unit. When software touches an address register, it emits a one-cycle pulse so that translation caches can be flushed.

Configuration bits are R (bit 0), W (bit 1), X (bit 2), match mode (bits 4:3) and L (bit 7). The match mode encodings are 0 for off, 1 for top-of-range (TOR), 2 for naturally aligned 4-byte and 3 for naturally aligned power of two. Configuration words live at CSR addresses 0x3A0 upward and address registers at 0x3B0 upward.

Top module: `pmp_regbank`

## Requirements
- R1: After reset with `NUM_ENTRIES` > 0, address register 0 holds all ones in its `PADDR_BITS-2` bits and configuration byte 0 holds 0x1F (R, W and X set, mode 3). Every other entry reads zero.
- R2: A stored configuration byte keeps only bits 0 to 4 and bit 7 of the written byte. Bits 5 and 6 are always stored as zero.
- R3: If a written configuration byte has bit 0 (R) clear and bit 1 (W) set, bit 1 is stored as zero.
- R4: A configuration byte whose bit 7 (L) is set ignores all writes. Other unlocked bytes in the same CSR word are still updated by that write.
- R5: A write to address register i is dropped while bit 7 of entry i's configuration is set.
- R6: A write to address register i is also dropped while entry i+1 has bit 7 set and match mode 1 (TOR). A locked neighbour in any other mode does not block the write.
- R7: Address registers store only the low `PADDR_BITS-2` bits of the write data, and they read back zero-extended.
- R8: Entries with an index from `NUM_ENTRIES` up to `MAX_ENTRIES-1` read as zero and ignore writes.
- R9: With `NUM_ENTRIES` = 0, every write to the protection CSRs is ignored and every register reads zero, including after reset.
- R10: A write to an address CSR in 0x3B0..0x3B0+`MAX_ENTRIES`-1 raises `flush_o` for exactly the next cycle, whether or not the write is accepted, when `NUM_ENTRIES` > 0. No other write raises it.
- R11: Read data follows `csr_addr` in the same cycle. Addresses outside both ranges read zero. On a 64-bit hart, only even-numbered configuration words exist, and odd ones read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | Write strobe, one write per cycle |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data |
| flush_o | output | 1 | One-cycle pulse after an address CSR write |
| ent_cfg_o | output | MAX_ENTRIES*8 | Stored configuration bytes, entry i at bits 8i+7..8i |
| ent_addr_o | output | MAX_ENTRIES*(PADDR_BITS-2) | Stored address registers, entry i in slice i |

## Verification
The case hardest to reach from the ports is the top-of-range lock on a neighbour. It needs the following entry's configuration byte to be written with L set and mode TOR first. That write must leave its locked sibling bytes in the same word untouched. Only then does a write to the preceding address register show whether it is refused. The stimulus walks through this order for both a TOR neighbour and a non-TOR locked neighbour. Separate instances with no implemented entries and with a 64-bit word cover the zero-count hardwiring and the odd configuration words.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int unsigned CFG_R    = 0;
  localparam int unsigned CFG_W    = 1;
  localparam int unsigned CFG_A_LO = 3;
  localparam int unsigned CFG_L    = 7;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_TOR   = 2'd1;
  localparam logic [1:0] MODE_NA4   = 2'd2;
  localparam logic [1:0] MODE_NAPOT = 2'd3;

  localparam logic [11:0] CSR_CFG_BASE  = 12'h3A0;
  localparam logic [11:0] CSR_ADDR_BASE = 12'h3B0;

  // bits that survive a configuration write: R, W, X, mode, L
  localparam logic [7:0] CFG_KEEP = 8'h9F;
  // reset value of entry 0: R|W|X with NAPOT mode
  localparam logic [7:0] CFG_OPEN = 8'h1F;

  function automatic logic [7:0] cfg_legalize(input logic [7:0] raw);
    logic [7:0] v;
    v = raw & CFG_KEEP;
    if (!v[CFG_R]) v[CFG_W] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
  import pmp_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [11:0]      csr_addr,
  output logic             addr_hit,
  output logic [IDX_W-1:0] addr_idx,
  output logic             cfg_hit,
  output logic [IDX_W-1:0] cfg_base
);
  localparam int unsigned NUM_CFG_CSR = MAX_ENTRIES / 4;

  logic [11:0] a_off;
  logic [11:0] c_off;
  logic        c_word_ok;

  assign a_off = csr_addr - CSR_ADDR_BASE;
  assign c_off = csr_addr - CSR_CFG_BASE;

  generate
    if (XLEN == 64) begin : g_rv64
      assign c_word_ok = ~c_off[0];
    end else begin : g_rv32
      assign c_word_ok = 1'b1;
    end
  endgenerate

  assign addr_hit = (csr_addr >= CSR_ADDR_BASE) && (a_off < 12'(MAX_ENTRIES));
  assign addr_idx = a_off[IDX_W-1:0];
  assign cfg_hit  = (csr_addr >= CSR_CFG_BASE) && (c_off < 12'(NUM_CFG_CSR)) && c_word_ok;
  assign cfg_base = {c_off[IDX_W-3:0], 2'b00};
endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 30,
  parameter bit          OPEN_AT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wbyte,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              next_tor_lock,
  output logic [7:0]        cfg_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic cfg_locked;
  logic addr_open;

  assign cfg_locked = cfg_q[CFG_L];
  assign addr_open  = !cfg_locked && !next_tor_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= OPEN_AT_RESET ? CFG_OPEN : 8'h00;
      addr_q <= OPEN_AT_RESET ? '1 : '0;
    end else begin
      if (cfg_we && !cfg_locked) cfg_q <= cfg_legalize(cfg_wbyte);
      if (addr_we && addr_open) addr_q <= addr_wdata;
    end
  end
endmodule

// File: rtl/pmp_read_mux.sv
module pmp_read_mux #(
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned ADDR_W      = 30,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [MAX_ENTRIES*8-1:0]      ent_cfg,
  input  logic [MAX_ENTRIES*ADDR_W-1:0] ent_addr,
  input  logic                          addr_hit,
  input  logic [IDX_W-1:0]              addr_idx,
  input  logic                          cfg_hit,
  input  logic [IDX_W-1:0]              cfg_base,
  output logic [XLEN-1:0]               rdata
);
  localparam int unsigned BYTES = XLEN / 8;

  logic [7:0]        cfg_arr  [MAX_ENTRIES];
  logic [ADDR_W-1:0] addr_arr [MAX_ENTRIES];

  generate
    for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_unpack
      assign cfg_arr[g]  = ent_cfg[g*8 +: 8];
      assign addr_arr[g] = ent_addr[g*ADDR_W +: ADDR_W];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr_hit) begin
      rdata = XLEN'(addr_arr[addr_idx]);
    end else if (cfg_hit) begin
      for (int k = 0; k < BYTES; k++) begin
        rdata[8*k +: 8] = cfg_arr[cfg_base + IDX_W'(k)];
      end
    end
  end
endmodule

// File: rtl/pmp_regbank.sv
module pmp_regbank
  import pmp_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned PADDR_BITS  = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [11:0]                            csr_addr,
  input  logic                                   csr_we,
  input  logic [XLEN-1:0]                        csr_wdata,
  output logic [XLEN-1:0]                        csr_rdata,
  output logic                                   flush_o,
  output logic [MAX_ENTRIES*8-1:0]               ent_cfg_o,
  output logic [MAX_ENTRIES*(PADDR_BITS-2)-1:0]  ent_addr_o
);
  localparam int unsigned ADDR_W = PADDR_BITS - 2;
  localparam int unsigned IDX_W  = $clog2(MAX_ENTRIES);
  localparam int unsigned BYTES  = XLEN / 8;

  logic             addr_hit;
  logic [IDX_W-1:0] addr_idx;
  logic             cfg_hit;
  logic [IDX_W-1:0] cfg_base;
  logic             flush_q;

  pmp_csr_decode #(
    .MAX_ENTRIES(MAX_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)
  ) u_dec (
    .csr_addr(csr_addr), .addr_hit(addr_hit), .addr_idx(addr_idx),
    .cfg_hit(cfg_hit), .cfg_base(cfg_base)
  );

  generate
    for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_ent
      if (i < NUM_ENTRIES) begin : g_impl
        logic addr_we_i;
        logic cfg_we_i;
        logic nxt_tor_lock;

        assign addr_we_i = csr_we && addr_hit && (addr_idx == IDX_W'(i));
        assign cfg_we_i  = csr_we && cfg_hit && (cfg_base == IDX_W'((i / BYTES) * BYTES));

        if (i + 1 < MAX_ENTRIES) begin : g_nxt
          assign nxt_tor_lock = ent_cfg_o[(i+1)*8 + CFG_L] &&
                                (ent_cfg_o[(i+1)*8 + CFG_A_LO +: 2] == MODE_TOR);
        end else begin : g_last
          assign nxt_tor_lock = 1'b0;
        end

        pmp_entry #(
          .ADDR_W(ADDR_W), .OPEN_AT_RESET(i == 0)
        ) u_ent (
          .clk(clk), .rst_n(rst_n),
          .cfg_we(cfg_we_i), .cfg_wbyte(csr_wdata[8*(i % BYTES) +: 8]),
          .addr_we(addr_we_i), .addr_wdata(csr_wdata[ADDR_W-1:0]),
          .next_tor_lock(nxt_tor_lock),
          .cfg_q(ent_cfg_o[i*8 +: 8]),
          .addr_q(ent_addr_o[i*ADDR_W +: ADDR_W])
        );
      end else begin : g_absent
        assign ent_cfg_o[i*8 +: 8]          = 8'h00;
        assign ent_addr_o[i*ADDR_W +: ADDR_W] = '0;
      end
    end
  endgenerate

  pmp_read_mux #(
    .MAX_ENTRIES(MAX_ENTRIES), .XLEN(XLEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_rd (
    .ent_cfg(ent_cfg_o), .ent_addr(ent_addr_o),
    .addr_hit(addr_hit), .addr_idx(addr_idx),
    .cfg_hit(cfg_hit), .cfg_base(cfg_base),
    .rdata(csr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= (NUM_ENTRIES > 0) && csr_we && addr_hit;
  end

  assign flush_o = flush_q;
endmodule

// File: rtl/pmp_regbank_chk.sv
module pmp_regbank_chk #(
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ADDR_W      = 30
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [11:0]                   csr_addr,
  input logic                          csr_we,
  input logic                          flush_o,
  input logic [MAX_ENTRIES*8-1:0]      ent_cfg_o,
  input logic [MAX_ENTRIES*ADDR_W-1:0] ent_addr_o
);
  logic wr_to_addr_csr;
  assign wr_to_addr_csr = csr_we && (NUM_ENTRIES > 0) &&
                          (csr_addr >= 12'h3B0) && (csr_addr < 12'h3B0 + 12'(MAX_ENTRIES));

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(wr_to_addr_csr)); // R10
  AST_FLUSH_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_to_addr_csr |=> flush_o); // R10

  generate
    for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_chk
      AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cfg_o[i*8+7] |=> $stable(ent_cfg_o[i*8 +: 8])); // R4
      AST_ADDR_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cfg_o[i*8+7] |=> $stable(ent_addr_o[i*ADDR_W +: ADDR_W])); // R5
      AST_NO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ent_cfg_o[i*8] && ent_cfg_o[i*8+1])); // R3
      AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cfg_o[i*8+5 +: 2] == 2'b00); // R2
      if (i + 1 < MAX_ENTRIES) begin : g_tor
        AST_TOR_NEIGHBOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
          (ent_cfg_o[(i+1)*8+7] && ent_cfg_o[(i+1)*8+3 +: 2] == 2'd1)
          |=> $stable(ent_addr_o[i*ADDR_W +: ADDR_W])); // R6
      end
      if (i >= NUM_ENTRIES) begin : g_abs
        AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
          ent_cfg_o[i*8 +: 8] == 8'h00 && ent_addr_o[i*ADDR_W +: ADDR_W] == '0); // R8
      end
    end
  endgenerate
endmodule

bind pmp_regbank pmp_regbank_chk #(
  .MAX_ENTRIES(MAX_ENTRIES), .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(PADDR_BITS - 2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
  .flush_o(flush_o), .ent_cfg_o(ent_cfg_o), .ent_addr_o(ent_addr_o)
);

// File: tb/sim_pmp_regbank.sv
module sim_pmp_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] caddr = 12'h000;
  logic [63:0] cdata = 64'h0;
  logic [2:0]  we = 3'b000;
  logic        done = 1'b0;
  int          n_checks = 0;
  int          n_fail = 0;

  logic [31:0]   rd0, rd1;
  logic [63:0]   rd2;
  logic          fl0, fl1, fl2;
  logic [127:0]  c0, c1, c2;
  logic [479:0]  a0, a1;
  logic [863:0]  a2;

  always #4 clk = ~clk;

  // 32-bit hart, 8 of 16 entries, 30-bit address registers
  pmp_regbank #(.XLEN(32), .MAX_ENTRIES(16), .NUM_ENTRIES(8), .PADDR_BITS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(caddr), .csr_we(we[0]), .csr_wdata(cdata[31:0]),
    .csr_rdata(rd0), .flush_o(fl0), .ent_cfg_o(c0), .ent_addr_o(a0));
  // no implemented entries
  pmp_regbank #(.XLEN(32), .MAX_ENTRIES(16), .NUM_ENTRIES(0), .PADDR_BITS(32)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_addr(caddr), .csr_we(we[1]), .csr_wdata(cdata[31:0]),
    .csr_rdata(rd1), .flush_o(fl1), .ent_cfg_o(c1), .ent_addr_o(a1));
  // 64-bit hart, 54-bit address registers
  pmp_regbank #(.XLEN(64), .MAX_ENTRIES(16), .NUM_ENTRIES(8), .PADDR_BITS(56)) u2 (
    .clk(clk), .rst_n(rst_n), .csr_addr(caddr), .csr_we(we[2]), .csr_wdata(cdata),
    .csr_rdata(rd2), .flush_o(fl2), .ent_cfg_o(c2), .ent_addr_o(a2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    caddr = a;
    cdata = d;
    we[sel] = 1'b1;
    @(negedge clk);
    we = 3'b000;
  endtask

  task automatic rd(input int sel, input logic [11:0] a, output logic [63:0] v);
    @(negedge clk);
    caddr = a;
    #1;
    case (sel)
      0:       v = {32'h0, rd0};
      1:       v = {32'h0, rd1};
      default: v = rd2;
    endcase
  endtask

  task automatic flush_of(input int sel, output logic f);
    #1;
    case (sel)
      0:       f = fl0;
      1:       f = fl1;
      default: f = fl2;
    endcase
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(0, 12'h3B0, v); chk("R1 addr0 reset", v, 64'h3FFF_FFFF);
    rd(0, 12'h3A0, v); chk("R1 cfg word0 reset", v, 64'h0000_001F);
    rd(0, 12'h3B1, v); chk("R1 addr1 reset", v, 64'h0);
    rd(0, 12'h3A1, v); chk("R1 cfg word1 reset", v, 64'h0);
  endtask

  task automatic t_mask_flush;
    logic [63:0] v;
    logic f;
    wr(0, 12'h3B1, 64'hFFFF_FFFF);
    flush_of(0, f); chk("R10 flush after addr write", {63'h0, f}, 64'h1);
    @(negedge clk);
    flush_of(0, f); chk("R10 flush one cycle", {63'h0, f}, 64'h0);
    rd(0, 12'h3B1, v); chk("R7 addr masked", v, 64'h3FFF_FFFF);
    wr(0, 12'h3B2, 64'h0000_1234);
    @(negedge clk);
    rd(0, 12'h3B2, v); chk("R7 addr plain value", v, 64'h1234);
  endtask

  task automatic t_legal;
    logic [63:0] v;
    logic f;
    // bytes: e4=FF (locks, keeps 9F), e5=02 (W only), e6=03, e7=60 (reserved)
    wr(0, 12'h3A1, 64'h6003_02FF);
    flush_of(0, f); chk("R10 no flush on cfg write", {63'h0, f}, 64'h0);
    rd(0, 12'h3A1, v); chk("R2 R3 legalized bytes", v, 64'h0003_009F);
  endtask

  task automatic t_lock;
    logic [63:0] v;
    wr(0, 12'h3A1, 64'h0101_0101);
    rd(0, 12'h3A1, v); chk("R4 locked byte kept, others written", v, 64'h0101_019F);
    wr(0, 12'h3B4, 64'h0000_0123);
    rd(0, 12'h3B4, v); chk("R5 locked addr ignores write", v, 64'h0);
    wr(0, 12'h3B5, 64'h0000_0055);
    rd(0, 12'h3B5, v); chk("R5 unlocked addr written", v, 64'h55);
  endtask

  task automatic t_tor;
    logic [63:0] v;
    // e6 = L|TOR|R = 0x89
    wr(0, 12'h3A1, 64'h0189_0100);
    rd(0, 12'h3A1, v); chk("R6 R4 neighbour set TOR lock", v, 64'h0189_019F);
    wr(0, 12'h3B5, 64'h0000_0077);
    rd(0, 12'h3B5, v); chk("R6 TOR-locked neighbour blocks", v, 64'h55);
    // e1 = L with NAPOT mode, not TOR
    wr(0, 12'h3A0, 64'h0000_9801);
    rd(0, 12'h3A0, v); chk("R4 cfg word0 rewrite", v, 64'h0000_9801);
    wr(0, 12'h3B0, 64'h0000_0ABC);
    rd(0, 12'h3B0, v); chk("R6 non-TOR locked neighbour allows", v, 64'hABC);
    wr(0, 12'h3A0, 64'h0000_0000);
    rd(0, 12'h3A0, v); chk("R4 locked e1 survives clear", v, 64'h0000_9800);
  endtask

  task automatic t_absent;
    logic [63:0] v;
    logic f;
    wr(0, 12'h3B8, 64'h0000_1234);
    flush_of(0, f); chk("R10 flush for absent addr in range", {63'h0, f}, 64'h1);
    rd(0, 12'h3B8, v); chk("R8 absent addr reads zero", v, 64'h0);
    wr(0, 12'h3A2, 64'hFFFF_FFFF);
    rd(0, 12'h3A2, v); chk("R8 absent cfg reads zero", v, 64'h0);
    wr(0, 12'h3C0, 64'hFFFF_FFFF);
    flush_of(0, f); chk("R10 no flush outside range", {63'h0, f}, 64'h0);
    rd(0, 12'h3C0, v); chk("R11 outside range reads zero", v, 64'h0);
  endtask

  task automatic t_comb_read;
    logic [31:0] x, y;
    @(negedge clk);
    caddr = 12'h3B5; #1; x = rd0;
    caddr = 12'h3B1; #1; y = rd0;
    chk("R11 same-cycle read first", {32'h0, x}, 64'h55);
    chk("R11 same-cycle read second", {32'h0, y}, 64'h3FFF_FFFF);
  endtask

  task automatic t_zero;
    logic [63:0] v;
    logic f;
    rd(1, 12'h3B0, v); chk("R9 zero count addr0 reset", v, 64'h0);
    rd(1, 12'h3A0, v); chk("R9 zero count cfg reset", v, 64'h0);
    wr(1, 12'h3B0, 64'h0000_0055);
    flush_of(1, f); chk("R10 R9 no flush with zero count", {63'h0, f}, 64'h0);
    rd(1, 12'h3B0, v); chk("R9 addr write ignored", v, 64'h0);
    wr(1, 12'h3A0, 64'h0000_0007);
    rd(1, 12'h3A0, v); chk("R9 cfg write ignored", v, 64'h0);
  endtask

  task automatic t_rv64;
    logic [63:0] v;
    rd(2, 12'h3B0, v); chk("R1 R7 rv64 addr0 reset", v, 64'h003F_FFFF_FFFF_FFFF);
    rd(2, 12'h3A0, v); chk("R1 rv64 cfg reset", v, 64'h1F);
    wr(2, 12'h3A0, 64'h0000_0003_0000_0000);
    rd(2, 12'h3A0, v); chk("R4 rv64 byte lanes", v, 64'h0000_0003_0000_0000);
    wr(2, 12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2, 12'h3A1, v); chk("R11 odd cfg word reads zero", v, 64'h0);
    rd(2, 12'h3A0, v); chk("R11 odd cfg write no effect", v, 64'h0000_0003_0000_0000);
    wr(2, 12'h3A2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2, 12'h3A2, v); chk("R8 rv64 absent cfg word", v, 64'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_flush();
    t_legal();
    t_lock();
    t_tor();
    t_absent();
    t_comb_read();
    t_zero();
    t_rv64();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule